// File: doc/BRIEF.md
# Paged GPIO Controller with Edge Interrupts

This block gives 48 general-purpose lines, grouped as six 8-bit ports, behind a small byte-wide register bus. Each port has an output latch that drives its pins. Reading a port returns the pin levels after a two-flop synchroniser. There is no direction control. Software uses a line as an input by leaving its latch bit at 0, which lets an external driver set the level.

The 24 lines on ports 0 to 2 can also raise edge interrupts. The polarity bits, the enable bits and the pending-line identifiers for those three ports all appear at the same three bus offsets. A two-bit page field picks which of them is visible. That page field sits in one register together with six per-port write locks. Each interrupt-capable line has its own pending flag. A single request output is high while any flag is set. A flag is cleared by turning its enable bit off and then back on.

Top module: `paged_gpio`

## Requirements
- R1: After reset, `pins_out` is all zero, `irq` is 0, and reads of offset 6 (pending summary) and offset 7 (page/lock) return 0x00.
- R2: A bus write to offset p (0 to 5) sets `pins_out[8p+7:8p]` from the next clock. A read of offset p returns `pins_in[8p+7:8p]` as sampled by a two-flop synchroniser.
- R3: Offset 7 holds the page field in bits 7:6 and the lock bits in bits 5:0, where bit p locks port p. While bit p is 1, writes to offset p are ignored, and reads of offset p still return the pin levels.
- R4: Offset 7 reads back what was last written to it. At offsets 8, 9 and 10 (ports 0, 1 and 2), page 1 (0x40) reads and writes the polarity byte and page 2 (0x80) reads and writes the enable byte. Page 0 reads 0x00 there and ignores writes.
- R5: A line on ports 0 to 2 whose enable bit is 1 and whose polarity bit is 1 sets its pending flag on a rising edge of its synchronised pin.
- R6: With polarity bit 0, the line sets its pending flag on a falling edge. A rising edge on that line leaves the flag clear.
- R7: Edges on a line whose enable bit is 0 never set its pending flag.
- R8: Writing 0 to a line's enable bit clears its pending flag. Writing the bit back to 1 does not bring the flag back.
- R9: A read of offset 6 returns, in bit p (p = 0 to 2), the OR of port p's pending flags. Bits 7:3 read 0.
- R10: On page 3 (0xC0), a read of offset 8+p returns port p's pending flags, one bit per line. Writes to offsets 8 to 10 on page 3 change no polarity or enable bit.
- R11: `irq` is 1 exactly while at least one pending flag is set.
- R12: Edges on ports 3 to 5 never raise `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 4 | Register offset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` (combinational) |
| pins_in | input | 48 | Pin levels seen at the pads |
| pins_out | output | 48 | Output latch values |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is a pending flag that has been set and then cleared through its enable bit, while a neighbouring line keeps its own flag. The bench reaches it by configuring polarity and enable through pages 1 and 2. It then creates edges that are wanted and edges that are not wanted on lines 0, 1 and 23, and reads the identifier bytes on page 3. Next it toggles a single enable bit off and on, and reads the identifiers again to show that only that line lost its flag. Locked-port writes and writes on page 3 are checked by reading back the latch outputs and, on page 2, the enable byte.

// File: rtl/pgpio_pkg.sv
package pgpio_pkg;
    // Register page selected by bits [PAGE_LSB+1:PAGE_LSB] of the page/lock byte
    typedef enum logic [1:0] {
        PG_NONE = 2'd0,
        PG_POL  = 2'd1,
        PG_EN   = 2'd2,
        PG_ID   = 2'd3
    } page_e;

    localparam int PAGE_LSB = 6;
endpackage

// File: rtl/pgpio_sync.sv
module pgpio_sync #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = raw_i;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign sync_o = sync_q.s2;
endmodule

// File: rtl/pgpio_irq_port.sv
module pgpio_irq_port #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    input  logic [W-1:0] pol_i,
    input  logic [W-1:0] en_i,
    output logic [W-1:0] pend_o
);
    typedef struct packed {
        logic [W-1:0] prev;
        logic [W-1:0] pend;
    } edge_t;

    edge_t edge_d, edge_q;
    logic [W-1:0] rise, fall, hit;

    always_comb begin
        rise        = pin_i & ~edge_q.prev;
        fall        = ~pin_i & edge_q.prev;
        hit         = (pol_i & rise) | (~pol_i & fall);
        edge_d      = edge_q;
        // previous sample tracks always, so re-enabling never sees a stale edge
        edge_d.prev = pin_i;
        // a disabled line holds no flag; an enabled one accumulates hits
        edge_d.pend = en_i & (edge_q.pend | hit);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) edge_q <= '0;
        else        edge_q <= edge_d;
    end

    assign pend_o = edge_q.pend;
endmodule

// File: rtl/pgpio_regs.sv
module pgpio_regs
    import pgpio_pkg::*;
#(
    parameter int PORT_W      = 8,
    parameter int N_PORTS     = 6,
    parameter int N_IRQ_PORTS = 3,
    parameter int ADDR_W      = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [PORT_W-1:0]             wr_data,
    output logic [N_PORTS*PORT_W-1:0]     lat_o,
    output logic [N_PORTS-1:0]            lock_o,
    output page_e                         page_o,
    output logic [N_IRQ_PORTS*PORT_W-1:0] pol_o,
    output logic [N_IRQ_PORTS*PORT_W-1:0] en_o
);
    localparam int OFS_PGLK  = N_PORTS + 1;
    localparam int OFS_PAGED = N_PORTS + 2;

    typedef struct packed {
        logic [N_PORTS-1:0][PORT_W-1:0]     lat;
        logic [N_PORTS-1:0]                 lock;
        page_e                              page;
        logic [N_IRQ_PORTS-1:0][PORT_W-1:0] pol;
        logic [N_IRQ_PORTS-1:0][PORT_W-1:0] en;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            for (int p = 0; p < N_PORTS; p++) begin
                if (addr == ADDR_W'(p) && !regs_q.lock[p])
                    regs_d.lat[p] = wr_data;
            end
            if (addr == ADDR_W'(OFS_PGLK)) begin
                regs_d.page = page_e'(wr_data[PAGE_LSB +: 2]);
                regs_d.lock = wr_data[N_PORTS-1:0];
            end
            for (int p = 0; p < N_IRQ_PORTS; p++) begin
                if (addr == ADDR_W'(OFS_PAGED + p)) begin
                    case (regs_q.page)
                        PG_POL:  regs_d.pol[p] = wr_data;
                        PG_EN:   regs_d.en[p]  = wr_data;
                        default: ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign lat_o  = regs_q.lat;
    assign lock_o = regs_q.lock;
    assign page_o = regs_q.page;
    assign pol_o  = regs_q.pol;
    assign en_o   = regs_q.en;
endmodule

// File: rtl/paged_gpio.sv
module paged_gpio
    import pgpio_pkg::*;
#(
    parameter int PORT_W      = 8,
    parameter int N_PORTS     = 6,
    parameter int N_IRQ_PORTS = 3,
    parameter int ADDR_W      = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         addr,
    input  logic                      wr_en,
    input  logic [PORT_W-1:0]         wr_data,
    output logic [PORT_W-1:0]         rd_data,
    input  logic [N_PORTS*PORT_W-1:0] pins_in,
    output logic [N_PORTS*PORT_W-1:0] pins_out,
    output logic                      irq
);
    localparam int N_LINES   = N_PORTS * PORT_W;
    localparam int N_IRQ_W   = N_IRQ_PORTS * PORT_W;
    localparam int OFS_PEND  = N_PORTS;
    localparam int OFS_PGLK  = N_PORTS + 1;
    localparam int OFS_PAGED = N_PORTS + 2;

    logic [N_LINES-1:0] pins_s;
    logic [N_PORTS-1:0] lock_w;
    page_e              page_w;
    logic [N_IRQ_W-1:0] pol_w, en_w, pend_w;

    pgpio_sync #(.W(N_LINES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (pins_in),
        .sync_o (pins_s)
    );

    pgpio_regs #(
        .PORT_W      (PORT_W),
        .N_PORTS     (N_PORTS),
        .N_IRQ_PORTS (N_IRQ_PORTS),
        .ADDR_W      (ADDR_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .lat_o   (pins_out),
        .lock_o  (lock_w),
        .page_o  (page_w),
        .pol_o   (pol_w),
        .en_o    (en_w)
    );

    for (genvar g = 0; g < N_IRQ_PORTS; g++) begin : g_irq
        pgpio_irq_port #(.W(PORT_W)) u_port (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (pins_s[g*PORT_W +: PORT_W]),
            .pol_i  (pol_w[g*PORT_W +: PORT_W]),
            .en_i   (en_w[g*PORT_W +: PORT_W]),
            .pend_o (pend_w[g*PORT_W +: PORT_W])
        );
    end

    always_comb begin
        rd_data = '0;
        for (int p = 0; p < N_PORTS; p++) begin
            if (addr == ADDR_W'(p))
                rd_data = pins_s[p*PORT_W +: PORT_W];
        end
        if (addr == ADDR_W'(OFS_PEND)) begin
            for (int p = 0; p < N_IRQ_PORTS; p++)
                rd_data[p] = |pend_w[p*PORT_W +: PORT_W];
        end
        if (addr == ADDR_W'(OFS_PGLK)) begin
            rd_data[PAGE_LSB +: 2]  = page_w;
            rd_data[N_PORTS-1:0]    = lock_w;
        end
        for (int p = 0; p < N_IRQ_PORTS; p++) begin
            if (addr == ADDR_W'(OFS_PAGED + p)) begin
                case (page_w)
                    PG_POL:  rd_data = pol_w[p*PORT_W +: PORT_W];
                    PG_EN:   rd_data = en_w[p*PORT_W +: PORT_W];
                    PG_ID:   rd_data = pend_w[p*PORT_W +: PORT_W];
                    default: rd_data = '0;
                endcase
            end
        end
    end

    assign irq = |pend_w;
endmodule

// File: rtl/paged_gpio_chk.sv
module paged_gpio_chk #(
    parameter int PORT_W      = 8,
    parameter int N_PORTS     = 6,
    parameter int N_IRQ_PORTS = 3,
    parameter int ADDR_W      = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [ADDR_W-1:0]             addr,
    input logic                          wr_en,
    input logic [PORT_W-1:0]             rd_data,
    input logic [N_PORTS*PORT_W-1:0]     pins_out,
    input logic                          irq,
    input logic [N_PORTS-1:0]            lock_w,
    input logic [1:0]                    page_w,
    input logic [N_IRQ_PORTS*PORT_W-1:0] pol_w,
    input logic [N_IRQ_PORTS*PORT_W-1:0] en_w,
    input logic [N_IRQ_PORTS*PORT_W-1:0] pend_w
);
    localparam int OFS_PEND  = N_PORTS;
    localparam int OFS_PAGED = N_PORTS + 2;

    logic locked_wr, id_page_wr;

    always_comb begin
        locked_wr = 1'b0;
        for (int p = 0; p < N_PORTS; p++)
            if (wr_en && addr == ADDR_W'(p) && lock_w[p]) locked_wr = 1'b1;
        id_page_wr = wr_en && page_w == 2'd3 &&
                     addr >= ADDR_W'(OFS_PAGED) &&
                     addr <  ADDR_W'(OFS_PAGED + N_IRQ_PORTS);
    end

    assert_locked_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        locked_wr |=> $stable(pins_out));

    assert_disabled_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_w & ~$past(en_w)) == '0));

    assert_summary_upper_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_W'(OFS_PEND)) |-> (rd_data[PORT_W-1:N_IRQ_PORTS] == '0));

    assert_id_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        id_page_wr |=> ($stable(en_w) && $stable(pol_w)));

    assert_irq_needs_enable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(en_w) != '0));
endmodule

bind paged_gpio paged_gpio_chk #(
    .PORT_W      (PORT_W),
    .N_PORTS     (N_PORTS),
    .N_IRQ_PORTS (N_IRQ_PORTS),
    .ADDR_W      (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .wr_en    (wr_en),
    .rd_data  (rd_data),
    .pins_out (pins_out),
    .irq      (irq),
    .lock_w   (lock_w),
    .page_w   (page_w),
    .pol_w    (pol_w),
    .en_w     (en_w),
    .pend_w   (pend_w)
);

// File: tb/tb_paged_gpio.sv
module tb_paged_gpio;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic [47:0] pins_in = '0;
    logic [47:0] pins_out;
    logic        irq;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    // scoreboard: kind 0 = rd_data, 1 = pins_out, 2 = irq
    int          kind_q[$];
    logic [63:0] exp_q[$];
    string       tag_q[$];
    event        smp;

    always #5 clk = ~clk;

    paged_gpio dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .pins_in(pins_in), .pins_out(pins_out), .irq(irq)
    );

    initial begin : monitor
        forever begin
            @(smp);
            while (kind_q.size() > 0) begin
                int          k;
                logic [63:0] e, a;
                string       t;
                k = kind_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a = (k == 0) ? {56'd0, rd_data} : (k == 1) ? {16'd0, pins_out} : {63'd0, irq};
                total++;
                if (a !== e) begin
                    fails++;
                    $display("FAIL %s: actual %0h expected %0h", t, a, e);
                end
            end
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic expect_item(input int k, input logic [3:0] a, input logic [63:0] e, input string t);
        @(negedge clk);
        addr = a;
        #2;
        kind_q.push_back(k); exp_q.push_back(e); tag_q.push_back(t);
        -> smp;
        #1;
    endtask

    task automatic exp_rd(input logic [3:0] a, input logic [7:0] e, input string t);
        expect_item(0, a, {56'd0, e}, t);
    endtask

    task automatic set_pins(input logic [47:0] v);
        @(negedge clk);
        pins_in = v;
        idle(4);
    endtask

    task automatic report;
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    initial begin : watchdog
        #2_000_000;
        total++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin : stim
        idle(3);
        rst_n = 1'b1;
        // R1 reset state
        expect_item(1, 4'd0, 64'd0, "R1 pins_out after reset");
        expect_item(2, 4'd0, 64'd0, "R1 irq after reset");
        exp_rd(4'd7, 8'h00, "R1 page/lock after reset");
        exp_rd(4'd6, 8'h00, "R1 summary after reset");

        // R2 latch writes and pin reads
        wr(4'd0, 8'hA5);
        wr(4'd5, 8'h3C);
        expect_item(1, 4'd0, {16'd0, 48'h3C00_0000_00A5}, "R2 latches ports 0 and 5");
        set_pins(48'h1122_3344_5566);
        exp_rd(4'd0, 8'h66, "R2 read port 0 pins");
        exp_rd(4'd4, 8'h22, "R2 read port 4 pins");

        // R3 lock port 0
        wr(4'd7, 8'h01);
        wr(4'd0, 8'hFF);
        expect_item(1, 4'd0, {16'd0, 48'h3C00_0000_00A5}, "R3 locked write ignored");
        exp_rd(4'd0, 8'h66, "R3 locked port still reads pins");
        exp_rd(4'd7, 8'h01, "R4 page/lock readback");
        set_pins(48'h0);

        // R4 polarity page: line 0 rising, others falling
        wr(4'd7, 8'h40);
        wr(4'd8, 8'h01);
        exp_rd(4'd8, 8'h01, "R4 polarity readback");
        // enable page: lines 0, 1 and 23
        wr(4'd7, 8'h80);
        wr(4'd8, 8'h03);
        wr(4'd10, 8'h80);
        exp_rd(4'd8, 8'h03, "R4 enable readback");

        // R5 / R6 rising edge on lines 0 and 1
        set_pins(48'h3);
        expect_item(2, 4'd0, 64'd1, "R11 irq with pending line 0");
        wr(4'd7, 8'hC0);
        exp_rd(4'd8, 8'h01, "R5 rising sets line 0, R6 rising ignored line 1");
        exp_rd(4'd6, 8'h01, "R9 summary port 0");
        // falling edges
        set_pins(48'h0);
        exp_rd(4'd8, 8'h03, "R6 falling sets line 1");
        set_pins(48'h80_0000);
        set_pins(48'h0);
        exp_rd(4'd10, 8'h80, "R6 falling sets line 23");
        exp_rd(4'd6, 8'h05, "R9 summary ports 0 and 2");
        // R7 disabled line 8 edges
        set_pins(48'h100);
        set_pins(48'h0);
        exp_rd(4'd9, 8'h00, "R7 disabled line stays clear");

        // R10 writes on ID page ignored
        wr(4'd8, 8'h00);
        exp_rd(4'd8, 8'h03, "R10 ID write leaves flags");
        wr(4'd7, 8'h80);
        exp_rd(4'd8, 8'h03, "R10 ID write leaves enables");

        // R8 clear line 0 only
        wr(4'd8, 8'h02);
        wr(4'd8, 8'h03);
        wr(4'd7, 8'hC0);
        exp_rd(4'd8, 8'h02, "R8 line 0 cleared, line 1 kept");
        wr(4'd7, 8'h80);
        wr(4'd8, 8'h00);
        wr(4'd10, 8'h00);
        wr(4'd8, 8'h03);
        wr(4'd10, 8'h80);
        expect_item(2, 4'd0, 64'd0, "R8 R11 irq low after clearing all");
        exp_rd(4'd6, 8'h00, "R8 summary clear after re-arm");

        // R12 ports 3..5 never interrupt
        set_pins(48'hFFFF_FF00_0000);
        set_pins(48'h0);
        expect_item(2, 4'd0, 64'd0, "R12 upper ports no irq");

        // R4 page 0 reads zero at paged offsets
        wr(4'd7, 8'h00);
        exp_rd(4'd8, 8'h00, "R4 page 0 reads zero");

        idle(2);
        if (kind_q.size() != 0) begin
            total++; fails++;
            $display("FAIL scoreboard: actual %0d pending expected 0", kind_q.size());
        end
        report();
    end
endmodule